// File: doc/BRIEF.md
# Answer-to-Reset Stream Parser

This block watches the bytes a smart card sends after it leaves reset and works out, byte by byte, where that answer ends. The length is not fixed. The block reads the initial character to learn the coding convention. It reads the format byte to learn which interface bytes follow and how many historical bytes close the stream. It then follows each chained descriptor byte to the next group of interface bytes. If any descriptor names a protocol other than T=0, one check byte is expected last. Every accepted byte is stored in a small buffer that can be read back at any time, and the total length is reported when the parse completes.

A host pulses `start` when it releases the card from reset. It then presents each received character with `rxValid`, or flags a reception fault or timeout with `rxErr`. From the first interface group the block extracts the rate-adjustment indices and the extra guard time. A reception fault ends the parse with an error code. So does a stream longer than the buffer. A clean parse ends with `done` held high until the next `start`.

Top module: `atr_parser`

## Requirements
- R1: After reset, busy, done and errFlag are 0, errCode is 0, atrLen is 0, conv is 0 (none), rateF and rateD are 1, guardN is 0, and ta1Seen and tc1Seen are 0.
- R2: A start pulse clears all results, sets busy and makes the next byte the initial character. A byte or rxErr presented while busy is 0 has no effect on any output.
- R3: The initial character sets conv: 0x3B gives 1 (direct), 0x3F gives 2 (inverse), any other value gives 3 (bad). A bad value does not stop the parse.
- R4: In the format byte and in every chaining byte, bits 4, 5, 6 and 7 announce the A, B, C and D interface bytes of the next group. Those bytes are taken in that order. A D byte's upper nibble announces the following group, and a group without a D byte ends the interface bytes.
- R5: After the interface bytes, exactly K historical bytes are taken, where K is the low nibble of the format byte.
- R6: The first group's A byte loads rateF from its upper nibble and rateD from its lower nibble and sets ta1Seen. The first group's C byte loads guardN and sets tc1Seen. A and C bytes of later groups change none of these.
- R7: If the low nibble of any chaining D byte is nonzero, one extra check byte is taken after the historical bytes. A low nibble of 0 in every D byte means no check byte.
- R8: One cycle after the final byte is accepted, done is 1, busy is 0 and atrLen equals the number of bytes taken. done stays 1 until the next start.
- R9: rxErr while busy ends the parse in the next cycle with errFlag 1 and errCode 1. atrLen keeps the count of bytes already taken, and rxErr has priority over a byte in the same cycle.
- R10: A byte that arrives while DEPTH bytes are already stored is not stored. It ends the parse with errFlag 1 and errCode 2, leaving atrLen at DEPTH (33 by default).
- R11: rdData shows, without delay, the byte stored at position rdAddr, with position 0 holding the initial character and positions following arrival order.
- R12: A start pulse during a parse abandons it and begins a fresh one whose results carry nothing from the abandoned one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new parse |
| rxValid | input | 1 | rxData holds a received character this cycle |
| rxData | input | 8 | Received character |
| rxErr | input | 1 | Reception fault or timeout this cycle |
| rdAddr | input | 6 | Buffer read position |
| rdData | output | 8 | Stored byte at rdAddr |
| busy | output | 1 | Parse in progress |
| done | output | 1 | Parse ended cleanly |
| errFlag | output | 1 | Parse ended with an error |
| errCode | output | 2 | 0 none, 1 reception fault, 2 overflow |
| atrLen | output | 6 | Number of bytes taken |
| conv | output | 2 | Coding convention: 0 none, 1 direct, 2 inverse, 3 bad |
| rateF | output | 4 | Clock-rate index from the first A byte |
| rateD | output | 4 | Baud-rate index from the first A byte |
| ta1Seen | output | 1 | First A byte was received |
| guardN | output | 8 | Extra guard time from the first C byte |
| tc1Seen | output | 1 | First C byte was received |

## Verification
Every result is registered on the rising edge that accepts the byte, the start pulse or the fault, so it is due exactly one cycle after that stimulus. The end-of-parse flags appear together with the final length on that same edge. The bench drives each stimulus just after a falling edge, holds it for one full cycle and samples on the next falling edge. At that point the accepting edge has passed and no later edge has. The read port is combinational, so stored bytes are checked at any falling edge with no added wait.

// File: rtl/atr_pkg.sv
package atr_pkg;

  typedef enum logic [1:0] {
    CONV_NONE    = 2'd0,
    CONV_DIRECT  = 2'd1,
    CONV_INVERSE = 2'd2,
    CONV_BAD     = 2'd3
  } convT;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_RX   = 2'd1,
    ERR_OVF  = 2'd2
  } errT;

  // Strobes from control to datapath, at most one capture kind per cycle.
  typedef struct packed {
    logic clr;
    logic store;
    logic capTs;
    logic capT0;
    logic capIface;
    logic decHist;
  } atrStrobesT;

  // Datapath view of the state it will hold after this cycle's strobes.
  typedef struct packed {
    logic [3:0] maskNext;
    logic       histNextZero;
    logic       tckNext;
    logic       full;
  } atrStatusT;

  localparam logic [7:0] TS_DIRECT  = 8'h3B;
  localparam logic [7:0] TS_INVERSE = 8'h3F;

endpackage

// File: rtl/atr_datapath.sv
module atr_datapath
  import atr_pkg::*;
#(
  parameter int DEPTH = 33,
  parameter int LENW  = $clog2(DEPTH + 1),
  parameter int ADDRW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  atrStrobesT       stb,
  input  logic [7:0]       byteIn,
  input  logic [ADDRW-1:0] rdAddr,
  output logic [7:0]       rdData,
  output atrStatusT        stat,
  output logic [LENW-1:0]  atrLen,
  output logic [1:0]       conv,
  output logic [3:0]       rateF,
  output logic [3:0]       rateD,
  output logic             ta1Seen,
  output logic [7:0]       guardN,
  output logic             tc1Seen
);

  localparam logic [LENW-1:0]  FULLCNT = LENW'(DEPTH);
  localparam logic [ADDRW-1:0] LASTADR = ADDRW'(DEPTH - 1);

  logic [7:0]      mem [DEPTH];
  logic [LENW-1:0] count;
  logic [3:0]      mask;
  logic [3:0]      histLeft;
  logic            tckNeed;
  logic            firstGroup;
  convT            convQ;

  // Which interface byte the current character is: lowest pending flag wins.
  logic isA, isB, isC, isD;
  always_comb begin
    isA = mask[0];
    isB = !mask[0] && mask[1];
    isC = (mask[1:0] == 2'b00) && mask[2];
    isD = (mask[2:0] == 3'b000) && mask[3];
  end

  logic [3:0] maskNxt;
  logic [3:0] histNxt;
  logic       tckNxt;
  always_comb begin
    maskNxt = mask;
    histNxt = histLeft;
    tckNxt  = tckNeed;
    if (stb.clr) begin
      maskNxt = '0;
      histNxt = '0;
      tckNxt  = 1'b0;
    end else begin
      if (stb.capT0) begin
        maskNxt = byteIn[7:4];
        histNxt = byteIn[3:0];
      end
      if (stb.capIface) begin
        if (isD) begin
          maskNxt = byteIn[7:4];
          tckNxt  = tckNeed || (byteIn[3:0] != 4'd0);
        end else begin
          maskNxt = mask & (mask - 4'd1);
        end
      end
      if (stb.decHist) histNxt = histLeft - 4'd1;
    end
  end

  always_comb begin
    stat.maskNext     = maskNxt;
    stat.histNextZero = (histNxt == 4'd0);
    stat.tckNext      = tckNxt;
    stat.full         = (count == FULLCNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mask     <= '0;
      histLeft <= '0;
      tckNeed  <= 1'b0;
    end else begin
      mask     <= maskNxt;
      histLeft <= histNxt;
      tckNeed  <= tckNxt;
    end
  end

  // Byte buffer and length counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (stb.clr) begin
      count <= '0;
    end else if (stb.store && (count < FULLCNT)) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!stb.clr && stb.store && (count < FULLCNT)) begin
      mem[count[ADDRW-1:0]] <= byteIn;
    end
  end

  assign rdData = (rdAddr <= LASTADR) ? mem[rdAddr] : 8'h00;
  assign atrLen = count;

  // Extracted fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convQ      <= CONV_NONE;
      rateF      <= 4'd1;
      rateD      <= 4'd1;
      ta1Seen    <= 1'b0;
      guardN     <= '0;
      tc1Seen    <= 1'b0;
      firstGroup <= 1'b1;
    end else if (stb.clr) begin
      convQ      <= CONV_NONE;
      rateF      <= 4'd1;
      rateD      <= 4'd1;
      ta1Seen    <= 1'b0;
      guardN     <= '0;
      tc1Seen    <= 1'b0;
      firstGroup <= 1'b1;
    end else begin
      if (stb.capTs) begin
        if (byteIn == TS_DIRECT)       convQ <= CONV_DIRECT;
        else if (byteIn == TS_INVERSE) convQ <= CONV_INVERSE;
        else                           convQ <= CONV_BAD;
      end
      if (stb.capIface && firstGroup && isA) begin
        rateF   <= byteIn[7:4];
        rateD   <= byteIn[3:0];
        ta1Seen <= 1'b1;
      end
      if (stb.capIface && firstGroup && isC) begin
        guardN  <= byteIn;
        tc1Seen <= 1'b1;
      end
      if (stb.capIface && isD) firstGroup <= 1'b0;
    end
  end

  assign conv = convQ;

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULLCNT);

  // R8
  store_counts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.store && !stb.clr && !stat.full) |=> (count == $past(count) + 1'b1));

  // R4
  iface_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capIface |-> (mask != 4'd0));

  // R6
  ta1_first_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ta1Seen && !stb.clr) |=> ($stable(rateF) && $stable(rateD)));

endmodule

// File: rtl/atr_control.sv
module atr_control
  import atr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       rxValid,
  input  logic       rxErr,
  input  atrStatusT  stat,
  output atrStrobesT stb,
  output logic       busy,
  output logic       done,
  output logic       errFlag,
  output logic [1:0] errCode
);

  typedef enum logic [2:0] {
    S_IDLE, S_TS, S_T0, S_IFACE, S_HIST, S_TCK, S_DONE, S_ERR
  } stateT;

  stateT state, stateNxt;
  errT   errQ, errNxt;

  logic inParse;
  assign inParse = (state == S_TS) || (state == S_T0) || (state == S_IFACE) ||
                   (state == S_HIST) || (state == S_TCK);

  logic takeByte;
  assign takeByte = !start && inParse && !rxErr && rxValid && !stat.full;

  // Strobes depend only on state and inputs
  always_comb begin
    stb          = '0;
    stb.clr      = start;
    stb.store    = takeByte;
    stb.capTs    = takeByte && (state == S_TS);
    stb.capT0    = takeByte && (state == S_T0);
    stb.capIface = takeByte && (state == S_IFACE);
    stb.decHist  = takeByte && (state == S_HIST);
  end

  // Where to go after a byte, from the datapath's post-byte view
  stateT routeNxt;
  always_comb begin
    if (stat.maskNext != 4'd0)  routeNxt = S_IFACE;
    else if (!stat.histNextZero) routeNxt = S_HIST;
    else if (stat.tckNext)       routeNxt = S_TCK;
    else                         routeNxt = S_DONE;
  end

  always_comb begin
    stateNxt = state;
    errNxt   = errQ;
    if (start) begin
      stateNxt = S_TS;
      errNxt   = ERR_NONE;
    end else if (inParse) begin
      if (rxErr) begin
        stateNxt = S_ERR;
        errNxt   = ERR_RX;
      end else if (rxValid) begin
        if (stat.full) begin
          stateNxt = S_ERR;
          errNxt   = ERR_OVF;
        end else begin
          unique case (state)
            S_TS:    stateNxt = S_T0;
            S_TCK:   stateNxt = S_DONE;
            default: stateNxt = routeNxt;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      errQ  <= ERR_NONE;
    end else begin
      state <= stateNxt;
      errQ  <= errNxt;
    end
  end

  assign busy    = inParse;
  assign done    = (state == S_DONE);
  assign errFlag = (state == S_ERR);
  assign errCode = errQ;

  // R9
  rx_fault_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rxErr && !start) |=> (errFlag && errCode == 2'd1));

  // R8
  done_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // R2
  start_enters_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (busy && !done && !errFlag));

  // R10
  ovf_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rxValid && !rxErr && !start && stat.full) |=> (errCode == 2'd2));

endmodule

// File: rtl/atr_parser.sv
module atr_parser
  import atr_pkg::*;
#(
  parameter int DEPTH = 33,
  parameter int LENW  = $clog2(DEPTH + 1),
  parameter int ADDRW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  input  logic             rxErr,
  input  logic [ADDRW-1:0] rdAddr,
  output logic [7:0]       rdData,
  output logic             busy,
  output logic             done,
  output logic             errFlag,
  output logic [1:0]       errCode,
  output logic [LENW-1:0]  atrLen,
  output logic [1:0]       conv,
  output logic [3:0]       rateF,
  output logic [3:0]       rateD,
  output logic             ta1Seen,
  output logic [7:0]       guardN,
  output logic             tc1Seen
);

  atrStrobesT stb;
  atrStatusT  stat;

  atr_control uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .rxValid (rxValid),
    .rxErr   (rxErr),
    .stat    (stat),
    .stb     (stb),
    .busy    (busy),
    .done    (done),
    .errFlag (errFlag),
    .errCode (errCode)
  );

  atr_datapath #(.DEPTH(DEPTH), .LENW(LENW), .ADDRW(ADDRW)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .byteIn  (rxData),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .stat    (stat),
    .atrLen  (atrLen),
    .conv    (conv),
    .rateF   (rateF),
    .rateD   (rateD),
    .ta1Seen (ta1Seen),
    .guardN  (guardN),
    .tc1Seen (tc1Seen)
  );

endmodule

// File: tb/atr_parser_test.sv
module atr_parser_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic       rxErr = 1'b0;
  logic [5:0] rdAddr = 6'd0;
  logic [7:0] rdData;
  logic       busy, done, errFlag, ta1Seen, tc1Seen;
  logic [1:0] errCode, conv;
  logic [5:0] atrLen;
  logic [3:0] rateF, rateD;
  logic [7:0] guardN;

  int testCnt = 0;
  int failCnt = 0;

  always #4 clk = ~clk;

  atr_parser uut (
    .clk(clk), .rstN(rstN), .start(start), .rxValid(rxValid), .rxData(rxData),
    .rxErr(rxErr), .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .done(done),
    .errFlag(errFlag), .errCode(errCode), .atrLen(atrLen), .conv(conv),
    .rateF(rateF), .rateD(rateD), .ta1Seen(ta1Seen), .guardN(guardN),
    .tc1Seen(tc1Seen)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Each driver starts just after a falling edge and returns at the next one,
  // after the accepting rising edge has registered the result.
  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    rxValid = 1'b1;
    rxData  = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic pulseErr();
    rxErr = 1'b1;
    @(negedge clk);
    rxErr = 1'b0;
  endtask

  task automatic readAt(input int a, input int exp, input string req);
    rdAddr = 6'(a);
    #1;
    check(req, "stored byte", int'(rdData), exp);
  endtask

  task automatic testReset();
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "errFlag", int'(errFlag), 0);
    check("R1", "atrLen", int'(atrLen), 0);
    check("R1", "conv", int'(conv), 0);
    check("R1", "rateF", int'(rateF), 1);
    check("R1", "rateD", int'(rateD), 1);
    check("R1", "guardN", int'(guardN), 0);
    check("R1", "ta1Seen", int'(ta1Seen), 0);
  endtask

  task automatic testIdleIgnored();
    sendByte(8'h3B);
    pulseErr();
    check("R2", "len while idle", int'(atrLen), 0);
    check("R2", "errFlag while idle", int'(errFlag), 0);
    check("R2", "conv while idle", int'(conv), 0);
  endtask

  task automatic testMinimal();
    pulseStart();
    check("R2", "busy after start", int'(busy), 1);
    sendByte(8'h3B);
    check("R3", "direct conv", int'(conv), 1);
    sendByte(8'h00);
    check("R8", "done", int'(done), 1);
    check("R8", "busy cleared", int'(busy), 0);
    check("R8", "len", int'(atrLen), 2);
    // done is held and later bytes are ignored
    sendByte(8'h77);
    check("R8", "done held", int'(done), 1);
    check("R2", "len after extra byte", int'(atrLen), 2);
  endtask

  task automatic testFullChain();
    logic [7:0] seq [15] = '{8'h3B, 8'hF5, 8'h96, 8'h00, 8'h02, 8'h81, 8'h31,
                             8'hFE, 8'h45, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'h5C};
    pulseStart();
    for (int i = 0; i < 14; i++) sendByte(seq[i]);
    check("R5", "not done before check byte", int'(done), 0);
    check("R7", "still busy before check byte", int'(busy), 1);
    sendByte(seq[14]);
    check("R7", "done after check byte", int'(done), 1);
    check("R4", "len", int'(atrLen), 15);
    check("R6", "rateF", int'(rateF), 9);
    check("R6", "rateD", int'(rateD), 6);
    check("R6", "guardN", int'(guardN), 2);
    check("R6", "tc1Seen", int'(tc1Seen), 1);
    readAt(0, 8'h3B, "R11");
    readAt(5, 8'h81, "R11");
    readAt(14, 8'h5C, "R11");
  endtask

  task automatic testLaterGroup();
    pulseStart();
    sendByte(8'h3B);
    sendByte(8'h90);
    sendByte(8'h18);
    sendByte(8'h10);
    check("R4", "not done before A of group 2", int'(done), 0);
    sendByte(8'h55);
    check("R7", "no check byte for T=0", int'(done), 1);
    check("R4", "len", int'(atrLen), 5);
    check("R6", "rateF kept from group 1", int'(rateF), 1);
    check("R6", "rateD kept from group 1", int'(rateD), 8);
    check("R6", "tc1Seen absent", int'(tc1Seen), 0);
  endtask

  task automatic testHistOnly();
    pulseStart();
    sendByte(8'h3F);
    sendByte(8'h03);
    sendByte(8'h01);
    sendByte(8'h02);
    check("R5", "not done after 2 of 3", int'(done), 0);
    sendByte(8'h03);
    check("R5", "done after K", int'(done), 1);
    check("R5", "len", int'(atrLen), 5);
    check("R3", "inverse conv", int'(conv), 2);
    check("R6", "ta1Seen absent", int'(ta1Seen), 0);
  endtask

  task automatic testBadConv();
    pulseStart();
    sendByte(8'h3C);
    sendByte(8'h00);
    check("R3", "bad conv", int'(conv), 3);
    check("R3", "bad conv still completes", int'(done), 1);
  endtask

  task automatic testRxErr();
    pulseStart();
    sendByte(8'h3B);
    sendByte(8'h02);
    sendByte(8'hAA);
    rxValid = 1'b1;
    rxData  = 8'hBB;
    pulseErr();
    rxValid = 1'b0;
    check("R9", "errFlag", int'(errFlag), 1);
    check("R9", "errCode", int'(errCode), 1);
    check("R9", "len", int'(atrLen), 3);
    check("R9", "done", int'(done), 0);
    sendByte(8'hCC);
    check("R9", "len after error", int'(atrLen), 3);
  endtask

  task automatic testOverflow();
    pulseStart();
    sendByte(8'h3B);
    sendByte(8'hF0);
    for (int i = 0; i < 31; i++) sendByte((i % 4 == 3) ? 8'hF0 : 8'(i));
    check("R10", "busy at full", int'(busy), 1);
    check("R10", "no error at full", int'(errFlag), 0);
    sendByte(8'hF0);
    check("R10", "errFlag", int'(errFlag), 1);
    check("R10", "errCode", int'(errCode), 2);
    check("R10", "len", int'(atrLen), 33);
    readAt(32, 8'd30, "R11");
  endtask

  task automatic testRestart();
    pulseStart();
    sendByte(8'h3B);
    sendByte(8'hF0);
    sendByte(8'h25);
    pulseStart();
    check("R12", "len cleared", int'(atrLen), 0);
    check("R12", "ta1Seen cleared", int'(ta1Seen), 0);
    sendByte(8'h3F);
    sendByte(8'h00);
    check("R12", "done", int'(done), 1);
    check("R12", "len", int'(atrLen), 2);
    check("R12", "rateF default", int'(rateF), 1);
    check("R12", "rateD default", int'(rateD), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdleIgnored();
    testMinimal();
    testFullChain();
    testLaterGroup();
    testHistOnly();
    testBadConv();
    testRxErr();
    testOverflow();
    testRestart();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule